// File: doc/BRIEF.md
# Write-Order Steered Configuration Front End

This block is the host-facing register port of a small serial channel. The host has two register selects. Select 1 is a command register. Select 0 is a shared data port. Each write to the shared port is sent to one of four destinations, chosen only by how many such writes have been accepted since the channel was last re-armed. In order, the destinations are: the mode word, the interrupt mask word, the baud-rate select word, and then the transmit buffer. Once the transmit buffer is reached, every later write goes there.

There is no dedicated reset pin for the channel function. Software re-arms the channel by setting the top bit of the command register and then clearing it. While that bit is stored high, the configuration words are held cleared, the order counter is held at its start, and the channel reports idle. After the third configuration write, a ready flag rises, and that flag enables the downstream transmit and receive paths. A transmit-buffer write produces a one-cycle load strobe, with the byte on a data bus, for the shifter that sits outside this block. A synchronous power-up reset puts the block in the same cleared state.

Top module: `seqcfg_loader`

## Requirements
- R1: After `rst` is high at a clock edge, `mode_word`, `imask_word`, `baud_word`, `ctrl_word` and `tx_data` are all zero, and `tx_load` and `cfg_ready` are low.
- R2: The first accepted write with `reg_sel`=0 after a re-arm stores `wr_data` in `mode_word`, visible after that clock edge.
- R3: The second accepted write with `reg_sel`=0 stores `wr_data` in `imask_word`.
- R4: The third accepted write with `reg_sel`=0 stores `wr_data` in `baud_word`, and `cfg_ready` is high from that edge onward.
- R5: The fourth and every later accepted write with `reg_sel`=0 raises `tx_load` for exactly the following cycle, with `tx_data` equal to the written byte. The three configuration words are left unchanged, and back-to-back writes give back-to-back strobes.
- R6: `cfg_ready` stays low until the third configuration write, and `tx_load` is never high while `cfg_ready` is low.
- R7: A command write with bit 7 of `wr_data` set clears `cfg_ready` and all three configuration words at that edge. While `ctrl_word` bit 7 is 1, writes with `reg_sel`=0 are ignored: no word changes and `tx_load` stays low.
- R8: After a command write that clears bit 7 while it was stored as 1, the next write with `reg_sel`=0 loads `mode_word` again, and the full order restarts.
- R9: A command write with bit 7 clear, while bit 7 is already stored as 0, shows up on `ctrl_word` and does not disturb the order counter or `cfg_ready`. Only the set-then-clear sequence restarts the order.
- R10: A cycle with `wr_en` low changes no output and gives no `tx_load` strobe, whatever `reg_sel` and `wr_data` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| wr_en | input | 1 | Host write strobe, one write per cycle |
| reg_sel | input | 1 | 0 = shared data port, 1 = command register |
| wr_data | input | DATA_W | Host write data |
| ctrl_word | output | DATA_W | Stored command register; bit 7 is the re-arm bit |
| mode_word | output | DATA_W | Latched mode word |
| imask_word | output | DATA_W | Latched interrupt mask word |
| baud_word | output | DATA_W | Latched baud-rate select word |
| tx_load | output | 1 | One-cycle transmit-buffer load strobe |
| tx_data | output | DATA_W | Byte for the transmit buffer |
| cfg_ready | output | 1 | High once configured; enables transmit and receive |

## Verification
A wrong order-counter value shows up on the first shared-port write after it occurs. The byte lands in the wrong word, or a strobe appears or goes missing, and this is visible one edge after the write. A counter or ready flag that fails to clear on the re-arm bit is exposed at the next shared-port write, because the write that should be dropped either changes a word or strobes. A failure to restart after the bit clears is exposed when the following write misses `mode_word`. Random traffic mixes command writes, with the re-arm bit both set and clear, into shared-port writes, so that every counter state meets every kind of write. All outputs are compared after each cycle.

// File: rtl/seqcfg_pkg.sv
`timescale 1ns/1ps
package seqcfg_pkg;

    // Destination of the next shared-port write; encoding is the write order.
    typedef enum logic [1:0] {
        DST_MODE  = 2'd0,
        DST_MASK  = 2'd1,
        DST_BAUD  = 2'd2,
        DST_TXBUF = 2'd3
    } dest_e;

    // Decoded one-hot load strobes for the register bank.
    typedef struct packed {
        logic txbuf;
        logic baud;
        logic mask;
        logic mode;
    } dest_stb_t;

    localparam logic SEL_DATA = 1'b0;
    localparam logic SEL_CMD  = 1'b1;

    // Advance the order, saturating on the transmit buffer.
    function automatic dest_e dest_advance(dest_e d);
        dest_e nxt;
        case (d)
            DST_MODE: nxt = DST_MASK;
            DST_MASK: nxt = DST_BAUD;
            default:  nxt = DST_TXBUF;
        endcase
        return nxt;
    endfunction

    function automatic dest_stb_t dest_decode(dest_e d, logic fire);
        dest_stb_t s;
        s.mode  = fire && (d == DST_MODE);
        s.mask  = fire && (d == DST_MASK);
        s.baud  = fire && (d == DST_BAUD);
        s.txbuf = fire && (d == DST_TXBUF);
        return s;
    endfunction

endpackage

// File: rtl/seqcfg_cmd.sv
`timescale 1ns/1ps
module seqcfg_cmd #(
    parameter int DATA_W  = 8,
    parameter int RST_BIT = DATA_W - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_cmd,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] cmd_q,
    output logic              sw_clear
);

    logic set_req;
    logic release_req;

    assign set_req     = wr_cmd && wr_data[RST_BIT];
    assign release_req = wr_cmd && !wr_data[RST_BIT] && cmd_q[RST_BIT];

    // Held clear while the bit is stored high, and on the set and release writes.
    assign sw_clear = set_req || release_req || cmd_q[RST_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
        end else if (wr_cmd) begin
            cmd_q <= wr_data;
        end
    end

    // R9
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_cmd |=> $stable(cmd_q));

endmodule

// File: rtl/seqcfg_steer.sv
`timescale 1ns/1ps
module seqcfg_steer
    import seqcfg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sw_clear,
    input  logic      wr_cfg,
    output dest_stb_t stb,
    output logic      cfg_ready
);

    dest_e cnt_q;
    logic  accept;

    assign accept = wr_cfg && !sw_clear;
    assign stb    = dest_decode(cnt_q, accept);

    always_ff @(posedge clk) begin
        if (rst || sw_clear) begin
            cnt_q     <= DST_MODE;
            cfg_ready <= 1'b0;
        end else if (accept) begin
            cnt_q <= dest_advance(cnt_q);
            if (cnt_q == DST_BAUD) begin
                cfg_ready <= 1'b1;
            end
        end
    end

    // R4
    ready_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_ready) |-> $past(wr_cfg && cnt_q == DST_BAUD));

    // R9
    ready_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cfg_ready) |-> $past(sw_clear));

    // R8
    rearm_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        sw_clear |=> (cnt_q == DST_MODE));

    // R5
    saturate_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == DST_TXBUF && !sw_clear) |=> (cnt_q == DST_TXBUF));

endmodule

// File: rtl/seqcfg_bank.sv
`timescale 1ns/1ps
module seqcfg_bank
    import seqcfg_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int N_WORDS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sw_clear,
    input  dest_stb_t         stb,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] cfg_words [N_WORDS],
    output logic              tx_load,
    output logic [DATA_W-1:0] tx_data
);

    logic [N_WORDS-1:0] ld;

    assign ld = N_WORDS'({stb.baud, stb.mask, stb.mode});

    for (genvar g = 0; g < N_WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst || sw_clear) begin
                cfg_words[g] <= '0;
            end else if (ld[g]) begin
                cfg_words[g] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_load <= 1'b0;
            tx_data <= '0;
        end else begin
            tx_load <= stb.txbuf;
            if (stb.txbuf) begin
                tx_data <= wr_data;
            end
        end
    end

    // R5
    tx_byte_chk: assert property (@(posedge clk) disable iff (rst)
        tx_load |-> (tx_data == $past(wr_data)));

    // R2
    mode_write_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg_words[0]) |-> $past(stb.mode || sw_clear));

    // R5
    tx_keeps_cfg_chk: assert property (@(posedge clk) disable iff (rst)
        $past(stb.txbuf) |-> $stable(cfg_words[2]));

endmodule

// File: rtl/seqcfg_loader.sv
`timescale 1ns/1ps
module seqcfg_loader
    import seqcfg_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int RST_BIT = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              reg_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] ctrl_word,
    output logic [DATA_W-1:0] mode_word,
    output logic [DATA_W-1:0] imask_word,
    output logic [DATA_W-1:0] baud_word,
    output logic              tx_load,
    output logic [DATA_W-1:0] tx_data,
    output logic              cfg_ready
);

    localparam int N_CFG = 3;

    logic              wr_cmd;
    logic              wr_cfg;
    logic              sw_clear;
    dest_stb_t         stb;
    logic [DATA_W-1:0] words [N_CFG];

    assign wr_cmd = wr_en && (reg_sel == SEL_CMD);
    assign wr_cfg = wr_en && (reg_sel == SEL_DATA);

    seqcfg_cmd #(.DATA_W(DATA_W), .RST_BIT(RST_BIT)) u_cmd (
        .clk      (clk),
        .rst      (rst),
        .wr_cmd   (wr_cmd),
        .wr_data  (wr_data),
        .cmd_q    (ctrl_word),
        .sw_clear (sw_clear)
    );

    seqcfg_steer u_steer (
        .clk       (clk),
        .rst       (rst),
        .sw_clear  (sw_clear),
        .wr_cfg    (wr_cfg),
        .stb       (stb),
        .cfg_ready (cfg_ready)
    );

    seqcfg_bank #(.DATA_W(DATA_W), .N_WORDS(N_CFG)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .sw_clear  (sw_clear),
        .stb       (stb),
        .wr_data   (wr_data),
        .cfg_words (words),
        .tx_load   (tx_load),
        .tx_data   (tx_data)
    );

    assign mode_word  = words[0];
    assign imask_word = words[1];
    assign baud_word  = words[2];

    // R6
    load_needs_ready_chk: assert property (@(posedge clk) disable iff (rst)
        tx_load |-> cfg_ready);

    // R7
    held_idle_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_word[RST_BIT] |-> (!cfg_ready && !tx_load && mode_word == '0 && baud_word == '0));

endmodule

// File: tb/seqcfg_loader_tb.sv
`timescale 1ns/1ps
module seqcfg_loader_tb;

    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic          reg_sel = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] ctrl_word, mode_word, imask_word, baud_word, tx_data;
    logic          tx_load, cfg_ready;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // expected model
    int            e_cnt;
    logic          e_ready, e_load;
    logic [DW-1:0] e_ctrl, e_mode, e_mask, e_baud, e_txd;

    always #5 clk = ~clk;

    seqcfg_loader #(.DATA_W(DW), .RST_BIT(7)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .reg_sel(reg_sel), .wr_data(wr_data),
        .ctrl_word(ctrl_word), .mode_word(mode_word), .imask_word(imask_word),
        .baud_word(baud_word), .tx_load(tx_load), .tx_data(tx_data), .cfg_ready(cfg_ready)
    );

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        e_cnt = 0; e_ready = 0; e_load = 0;
        e_ctrl = '0; e_mode = '0; e_mask = '0; e_baud = '0; e_txd = '0;
    endtask

    function automatic void model_step(logic we, logic sel, logic [DW-1:0] d);
        e_load = 1'b0;
        if (!we) return;
        if (sel) begin
            if (d[7] || e_ctrl[7]) begin
                e_cnt = 0; e_ready = 0;
                e_mode = '0; e_mask = '0; e_baud = '0;
            end
            e_ctrl = d;
        end else if (!e_ctrl[7]) begin
            case (e_cnt)
                0: begin e_mode = d; e_cnt = 1; end
                1: begin e_mask = d; e_cnt = 2; end
                2: begin e_baud = d; e_cnt = 3; e_ready = 1; end
                default: begin e_load = 1; e_txd = d; end
            endcase
        end
    endfunction

    task automatic check_all(string ctx);
        chk("R2", {ctx, " mode_word"},  mode_word,  e_mode);
        chk("R3", {ctx, " imask_word"}, imask_word, e_mask);
        chk("R4", {ctx, " baud_word"},  baud_word,  e_baud);
        chk("R5", {ctx, " tx_load"},    tx_load,    e_load);
        chk("R5", {ctx, " tx_data"},    tx_data,    e_txd);
        chk("R6", {ctx, " cfg_ready"},  cfg_ready,  e_ready);
        chk("R9", {ctx, " ctrl_word"},  ctrl_word,  e_ctrl);
    endtask

    // One cycle of traffic; results sampled 1 ns after the edge.
    task automatic cyc(logic we, logic sel, logic [DW-1:0] d, string ctx);
        @(negedge clk);
        wr_en = we; reg_sel = sel; wr_data = d;
        @(posedge clk);
        #1;
        model_step(we, sel, d);
        check_all(ctx);
    endtask

    initial begin
        void'($urandom(32'h5A17_C0DE));
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        // R1: power-up state
        chk("R1", "ctrl_word", ctrl_word, 0);
        chk("R1", "mode_word", mode_word, 0);
        chk("R1", "imask_word", imask_word, 0);
        chk("R1", "baud_word", baud_word, 0);
        chk("R1", "tx_load", tx_load, 0);
        chk("R1", "tx_data", tx_data, 0);
        chk("R1", "cfg_ready", cfg_ready, 0);
        @(negedge clk); rst = 1'b0;

        // R2 R3 R4 R6: configuration order
        cyc(1, 0, 8'hA5, "R2 mode");
        chk("R6", "ready after mode", cfg_ready, 0);
        cyc(1, 0, 8'h3C, "R3 mask");
        chk("R6", "ready after mask", cfg_ready, 0);
        cyc(1, 0, 8'h81, "R4 baud");
        chk("R4", "ready after baud", cfg_ready, 1);
        // R5: back-to-back transmit writes
        cyc(1, 0, 8'h11, "R5 tx1");
        chk("R5", "strobe 1", tx_load, 1);
        cyc(1, 0, 8'h22, "R5 tx2");
        chk("R5", "strobe 2 data", tx_data, 8'h22);
        cyc(0, 0, 8'h77, "R10 idle");
        chk("R5", "strobe single cycle", tx_load, 0);
        chk("R10", "idle keeps tx_data", tx_data, 8'h22);
        // R9: command write without re-arm bit
        cyc(1, 1, 8'h05, "R9 cmd");
        cyc(1, 0, 8'h33, "R9 still tx");
        chk("R9", "no restart", tx_load, 1);
        chk("R9", "mode kept", mode_word, 8'hA5);
        // R7: set re-arm bit
        cyc(1, 1, 8'h80, "R7 set");
        chk("R7", "ready dropped", cfg_ready, 0);
        chk("R7", "mode cleared", mode_word, 0);
        cyc(1, 0, 8'h55, "R7 ignored");
        chk("R7", "ignored write strobe", tx_load, 0);
        chk("R7", "ignored write mode", mode_word, 0);
        // R8: clear bit, order restarts
        cyc(1, 1, 8'h00, "R8 release");
        cyc(1, 0, 8'h66, "R8 mode");
        chk("R8", "restart loads mode", mode_word, 8'h66);
        cyc(0, 1, 8'hFF, "R10 idle cmd");
        chk("R10", "idle cmd ignored", ctrl_word, 8'h00);

        // Random traffic
        for (int i = 0; i < 600; i++) begin
            int unsigned r = $urandom_range(0, 99);
            logic [DW-1:0] d = DW'($urandom);
            if (r < 15)       cyc(0, r[0], d, "R10 rand idle");
            else if (r < 25)  cyc(1, 1, {1'b1, d[6:0]}, "R7 rand set");
            else if (r < 33)  cyc(1, 1, {1'b0, d[6:0]}, "R8 rand cmd");
            else              cyc(1, 0, d, "R5 rand data");
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule